// File: doc/BRIEF.md
# YCbCr 4:2:2 Byte Stream Component Demultiplexer

This block takes an 8-bit byte stream that carries video samples one byte at a time, marked by a valid strobe. It regroups those bytes into whole pixels, each with three 8-bit components. The block has two formats.

In the luma/chroma format, each pixel pair carries four bytes: two chroma samples and two luma samples. Both pixels of the pair get the same chroma pair. In the serial colour format, each pixel carries three colour bytes, one after another.

One control input selects which chroma byte comes first, or whether the colour bytes arrive red-first or blue-first. A second control input mirrors every output component across the full 8-bit range. A line-start strobe realigns the byte phase at the start of each line. The block does no colour-space conversion and does not parse embedded sync codes.

Top module: `byte_pixel_demux`

## Requirements
- R1: With `fmt_rgb`=0 and `swap`=0, the bytes of a pixel pair arrive in the order Cb, Y0, Cr, Y1. The outputs are `px_c0`=Y, `px_c1`=Cb and `px_c2`=Cr.
- R2: With `fmt_rgb`=0 and `swap`=1, the chroma order is reversed: the pair arrives as Cr, Y0, Cb, Y1. The outputs keep the assignment `px_c0`=Y, `px_c1`=Cb, `px_c2`=Cr.
- R3: Both pixels of a pair carry the same Cb and Cr. The even pixel is emitted on the second chroma byte, using the Y0 already held. The odd pixel is emitted on its own Y1 byte.
- R4: With `fmt_rgb`=1 and `swap`=0, three bytes form a pixel in the order R, G, B. The outputs are `px_c0`=R, `px_c1`=G, `px_c2`=B. In this format the byte phase counts 0, 1, 2 and then wraps.
- R5: With `fmt_rgb`=1 and `swap`=1, the bytes arrive as B, G, R. The outputs still give `px_c0`=R, `px_c1`=G, `px_c2`=B.
- R6: With `invert`=1, each output component is 255 minus its value. With `invert`=0, the components pass unchanged. `invert` is sampled one cycle after the final byte of a pixel.
- R7: A high `line_start` makes the byte accepted in the same cycle the first byte of a group. A `line_start` with no byte in that cycle makes the next accepted byte the first byte. A partly collected group is dropped.
- R8: A cycle with `in_valid` low is ignored. Whatever is on `in_byte` in that cycle does not advance the phase and is not stored.
- R9: `px_valid` is high for exactly one cycle per completed pixel. It rises in the cycle after the second rising edge counted from the edge that accepts the pixel's final byte. The components hold their value between pulses.
- R10: While `rst` is high, `px_valid` is 0, the components are 0 and the byte phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| in_byte | input | 8 | Multiplexed byte |
| line_start | input | 1 | Realigns the byte phase to the first byte of a group |
| fmt_rgb | input | 1 | 0 = luma/chroma pairs, 1 = three colour bytes per pixel |
| swap | input | 1 | Reverses the chroma order, or the colour order |
| invert | input | 1 | Outputs 255 minus each component |
| px_valid | output | 1 | One-cycle pulse per completed pixel |
| px_c0 | output | 8 | Y, or R |
| px_c1 | output | 8 | Cb, or G |
| px_c2 | output | 8 | Cr, or B |

## Verification
The hardest case to reach from the ports is a group cut short by the line-start strobe. The earlier bytes are held inside the block, but they must never show up at the outputs.

The bench sends two bytes of a pair, then restarts the line, both with a strobe that carries a byte and with a strobe alone. It then checks that the pixels emitted afterwards use only the new bytes, and that no extra pulse appears.

Idle cycles with changing data are placed between bytes. The bench compares each pulse's cycle with the edge that accepted the final byte, which shows that idle cycles cannot advance the phase.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    localparam int COMP_W   = 8;
    localparam int PH_W     = 2;
    localparam int YCC_LAST = 3;
    localparam int RGB_LAST = 2;

    typedef enum logic {
        FMT_YCC = 1'b0,
        FMT_RGB = 1'b1
    } fmt_e;

    typedef logic [COMP_W-1:0] comp_t;
    typedef logic [PH_W-1:0]   phase_t;

    typedef struct packed {
        comp_t c0;
        comp_t c1;
        comp_t c2;
    } pixel_t;

    function automatic phase_t last_phase(fmt_e f);
        return (f == FMT_RGB) ? phase_t'(RGB_LAST) : phase_t'(YCC_LAST);
    endfunction

    // full-range mirror: max - v equals the bitwise complement
    function automatic pixel_t mirror_px(pixel_t p);
        pixel_t r;
        r.c0 = ~p.c0;
        r.c1 = ~p.c1;
        r.c2 = ~p.c2;
        return r;
    endfunction

    // picks the earlier or the later byte of a swappable pair
    function automatic comp_t pick(logic swap, comp_t early, comp_t late, logic want_early);
        return (swap ^ want_early) ? early : late;
    endfunction
endpackage

// File: rtl/bpd_phase_tracker.sv
module bpd_phase_tracker
    import bpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   line_start,
    input  fmt_e   fmt,
    output phase_t cur_phase,
    output logic   cur_last,
    output phase_t phase_q
);
    // a line start forces the byte of this cycle to be the first one
    assign cur_phase = line_start ? '0 : phase_q;
    assign cur_last  = (cur_phase == last_phase(fmt));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (in_valid) begin
            phase_q <= cur_last ? '0 : phase_t'(cur_phase + 1'b1);
        end else if (line_start) begin
            phase_q <= '0;
        end
    end
endmodule

// File: rtl/bpd_pixel_assembler.sv
module bpd_pixel_assembler
    import bpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  comp_t  in_byte,
    input  phase_t cur_phase,
    input  fmt_e   fmt,
    input  logic   swap,
    output logic   st_valid,
    output pixel_t st_px
);
    localparam int SLOTS = YCC_LAST;

    comp_t  slot_q [SLOTS];
    logic   done;
    pixel_t px;
    comp_t  chroma_late;

    // second chroma byte: the current byte at phase 2, the held one at phase 3
    assign chroma_late = (cur_phase == phase_t'(2)) ? in_byte : slot_q[2];

    always_comb begin
        done = 1'b0;
        px   = '0;
        if (fmt == FMT_RGB) begin
            if (cur_phase == phase_t'(RGB_LAST)) begin
                done  = 1'b1;
                px.c0 = pick(swap, slot_q[0], in_byte, 1'b1);
                px.c1 = slot_q[1];
                px.c2 = pick(swap, slot_q[0], in_byte, 1'b0);
            end
        end else begin
            if (cur_phase == phase_t'(2)) begin
                done  = 1'b1;
                px.c0 = slot_q[1];
            end else if (cur_phase == phase_t'(YCC_LAST)) begin
                done  = 1'b1;
                px.c0 = in_byte;
            end
            px.c1 = pick(swap, slot_q[0], chroma_late, 1'b1);
            px.c2 = pick(swap, slot_q[0], chroma_late, 1'b0);
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[s] <= '0;
            end else if (in_valid && cur_phase == phase_t'(s)) begin
                slot_q[s] <= in_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_px    <= '0;
        end else begin
            st_valid <= in_valid && done;
            if (in_valid && done) begin
                st_px <= px;
            end
        end
    end
endmodule

// File: rtl/bpd_finisher.sv
module bpd_finisher
    import bpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   st_valid,
    input  pixel_t st_px,
    input  logic   invert,
    output logic   out_valid,
    output pixel_t out_px
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_px    <= '0;
        end else begin
            out_valid <= st_valid;
            if (st_valid) begin
                out_px <= invert ? mirror_px(st_px) : st_px;
            end
        end
    end
endmodule

// File: rtl/byte_pixel_demux.sv
module byte_pixel_demux
    import bpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       line_start,
    input  logic       fmt_rgb,
    input  logic       swap,
    input  logic       invert,
    output logic       px_valid,
    output logic [7:0] px_c0,
    output logic [7:0] px_c1,
    output logic [7:0] px_c2
);
    fmt_e   fmt;
    phase_t cur_phase;
    phase_t phase_q;
    logic   cur_last;
    logic   st_valid;
    pixel_t st_px;
    pixel_t out_px;

    assign fmt = fmt_e'(fmt_rgb);

    bpd_phase_tracker u_phase (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .line_start (line_start),
        .fmt        (fmt),
        .cur_phase  (cur_phase),
        .cur_last   (cur_last),
        .phase_q    (phase_q)
    );

    bpd_pixel_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (comp_t'(in_byte)),
        .cur_phase (cur_phase),
        .fmt       (fmt),
        .swap      (swap),
        .st_valid  (st_valid),
        .st_px     (st_px)
    );

    bpd_finisher u_fin (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_px     (st_px),
        .invert    (invert),
        .out_valid (px_valid),
        .out_px    (out_px)
    );

    assign px_c0 = out_px.c0;
    assign px_c1 = out_px.c1;
    assign px_c2 = out_px.c2;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       line_start,
    input logic       fmt_rgb,
    input logic       px_valid,
    input logic [7:0] px_c0,
    input logic [7:0] px_c1,
    input logic [7:0] px_c2,
    input logic [1:0] phase
);
    assert_pulse_source_R9: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> $past(in_valid, 2));

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
        !px_valid |-> ($stable(px_c0) && $stable(px_c1) && $stable(px_c2)));

    assert_line_realign_R7: assert property (@(posedge clk) disable iff (rst)
        (line_start && !in_valid) |=> (phase == 2'd0));

    assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !line_start) |=> $stable(phase));

    assert_rgb_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_rgb) |=> (phase != 2'd3));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!px_valid && phase == 2'd0));
endmodule

bind byte_pixel_demux bpd_checker u_bpd_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .line_start (line_start),
    .fmt_rgb    (fmt_rgb),
    .px_valid   (px_valid),
    .px_c0      (px_c0),
    .px_c1      (px_c1),
    .px_c2      (px_c2),
    .phase      (phase_q)
);

// File: tb/test_byte_pixel_demux.sv
`timescale 1ns/1ps
module test_byte_pixel_demux;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       line_start;
    logic       fmt_rgb;
    logic       swap;
    logic       invert;
    logic       px_valid;
    logic [7:0] px_c0, px_c1, px_c2;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    int gcnt  = 0;
    int base  = 0;
    int last_edge = 0;
    bit done  = 1'b0;
    logic [7:0] g0 [0:63];
    logic [7:0] g1 [0:63];
    logic [7:0] g2 [0:63];
    int         gcyc [0:63];

    always #5 clk = ~clk;

    byte_pixel_demux i_byte_pixel_demux (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .line_start(line_start), .fmt_rgb(fmt_rgb), .swap(swap), .invert(invert),
        .px_valid(px_valid), .px_c0(px_c0), .px_c1(px_c1), .px_c2(px_c2)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && px_valid && gcnt < 64) begin
            g0[gcnt]   = px_c0;
            g1[gcnt]   = px_c1;
            g2[gcnt]   = px_c2;
            gcyc[gcnt] = cyc;
            gcnt       = gcnt + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b, logic ls);
        @(negedge clk);
        in_valid   = 1'b1;
        in_byte    = b;
        line_start = ls;
        last_edge  = cyc + 1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            line_start = 1'b0;
            in_byte    = 8'hA5 ^ 8'(i * 37);
        end
    endtask

    task automatic start(logic f, logic s, logic inv);
        idle(3);
        fmt_rgb = f;
        swap    = s;
        invert  = inv;
        base    = gcnt;
    endtask

    task automatic expect_px(string tag, int idx, logic [7:0] e0, logic [7:0] e1, logic [7:0] e2);
        chk({tag, " c0"}, g0[base+idx], e0);
        chk({tag, " c1"}, g1[base+idx], e1);
        chk({tag, " c2"}, g2[base+idx], e2);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; line_start = 1'b0;
        fmt_rgb = 1'b0; swap = 1'b0; invert = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 px_valid in reset", px_valid, 0);
        chk("R10 c0 in reset", px_c0, 0);
        chk("R10 c1 in reset", px_c1, 0);
        chk("R10 c2 in reset", px_c2, 0);
        rst = 1'b0;
    endtask

    task automatic t_ycc_plain;
        start(1'b0, 1'b0, 1'b0);
        send(8'h10, 1'b1); send(8'h20, 1'b0); send(8'h30, 1'b0); send(8'h40, 1'b0);
        send(8'h50, 1'b0); send(8'h60, 1'b0); send(8'h70, 1'b0); send(8'h80, 1'b0);
        idle(4);
        chk("R3 ycc pixel count", gcnt - base, 4);
        expect_px("R1 ycc even0", 0, 8'h20, 8'h10, 8'h30);
        expect_px("R3 ycc odd0 shares chroma", 1, 8'h40, 8'h10, 8'h30);
        expect_px("R1 ycc even1", 2, 8'h60, 8'h50, 8'h70);
        expect_px("R3 ycc odd1 shares chroma", 3, 8'h80, 8'h50, 8'h70);
    endtask

    task automatic t_ycc_swap;
        start(1'b0, 1'b1, 1'b0);
        send(8'hC1, 1'b1); send(8'h21, 1'b0); send(8'hB1, 1'b0); send(8'h41, 1'b0);
        idle(4);
        chk("R2 swap pixel count", gcnt - base, 2);
        expect_px("R2 swap even", 0, 8'h21, 8'hB1, 8'hC1);
        expect_px("R2 swap odd", 1, 8'h41, 8'hB1, 8'hC1);
    endtask

    task automatic t_rgb;
        start(1'b1, 1'b0, 1'b0);
        send(8'h11, 1'b1); send(8'h22, 1'b0); send(8'h33, 1'b0);
        send(8'h44, 1'b0); send(8'h55, 1'b0); send(8'h66, 1'b0);
        idle(4);
        chk("R4 rgb pixel count", gcnt - base, 2);
        expect_px("R4 rgb px0", 0, 8'h11, 8'h22, 8'h33);
        expect_px("R4 rgb px1", 1, 8'h44, 8'h55, 8'h66);
        start(1'b1, 1'b1, 1'b0);
        send(8'h33, 1'b1); send(8'h22, 1'b0); send(8'h11, 1'b0);
        idle(4);
        chk("R5 bgr pixel count", gcnt - base, 1);
        expect_px("R5 bgr px0", 0, 8'h11, 8'h22, 8'h33);
    endtask

    task automatic t_invert;
        start(1'b0, 1'b0, 1'b1);
        send(8'h00, 1'b1); send(8'hFF, 1'b0); send(8'h12, 1'b0); send(8'h34, 1'b0);
        idle(4);
        chk("R6 invert pixel count", gcnt - base, 2);
        expect_px("R6 invert even", 0, 8'h00, 8'hFF, 8'hED);
        expect_px("R6 invert odd", 1, 8'hCB, 8'hFF, 8'hED);
    endtask

    task automatic t_gaps;
        int e_even, e_odd;
        start(1'b0, 1'b0, 1'b0);
        send(8'h0A, 1'b1); idle(2);
        send(8'h0B, 1'b0); idle(3);
        send(8'h0C, 1'b0); e_even = last_edge; idle(1);
        send(8'h0D, 1'b0); e_odd = last_edge; idle(5);
        chk("R8 idle bytes ignored count", gcnt - base, 2);
        expect_px("R8 gapped even", 0, 8'h0B, 8'h0A, 8'h0C);
        expect_px("R8 gapped odd", 1, 8'h0D, 8'h0A, 8'h0C);
        chk("R9 latency even", gcyc[base], e_even + 1);
        chk("R9 latency odd", gcyc[base+1], e_odd + 1);
        start(1'b0, 1'b0, 1'b0);
        send(8'h01, 1'b1); send(8'h02, 1'b0); send(8'h03, 1'b0); e_even = last_edge;
        send(8'h04, 1'b0); idle(4);
        chk("R9 back-to-back pulses count", gcnt - base, 2);
        chk("R9 back-to-back first", gcyc[base], e_even + 1);
        chk("R9 back-to-back second", gcyc[base+1], e_even + 2);
    endtask

    task automatic t_linestart;
        start(1'b0, 1'b0, 1'b0);
        send(8'h33, 1'b1); send(8'h44, 1'b0);
        send(8'h05, 1'b1); send(8'h06, 1'b0); send(8'h07, 1'b0); send(8'h08, 1'b0);
        idle(4);
        chk("R7 restart with byte count", gcnt - base, 2);
        expect_px("R7 restart with byte even", 0, 8'h06, 8'h05, 8'h07);
        expect_px("R7 restart with byte odd", 1, 8'h08, 8'h05, 8'h07);
        start(1'b0, 1'b0, 1'b0);
        send(8'h09, 1'b1);
        @(negedge clk); in_valid = 1'b0; line_start = 1'b1;
        idle(1);
        send(8'h01, 1'b0); send(8'h02, 1'b0); send(8'h03, 1'b0); send(8'h04, 1'b0);
        idle(4);
        chk("R7 bare restart count", gcnt - base, 2);
        expect_px("R7 bare restart even", 0, 8'h02, 8'h01, 8'h03);
        expect_px("R7 bare restart odd", 1, 8'h04, 8'h01, 8'h03);
    endtask

    initial begin
        t_reset();
        t_ycc_plain();
        t_ycc_swap();
        t_rgb();
        t_invert();
        t_gaps();
        t_linestart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule